// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox Channel

This block is one byte-wide mailbox channel between a host I/O port and a management controller. The host sees two 16-bit I/O addresses: a data address and a command/status address. The management side sees four small registers. A host write to either address lands in an input byte register and raises the input-full flag. A management write to the output byte register raises the output-full flag, which a host read of the data address clears. The command/data flag records which of the two host addresses was last written.

The data address comes from a configuration input. By default the status address is inferred from it, either one above or four above, depending on a stride select. An override enable replaces the inferred status address with a configuration input of its own. The channel answers host cycles only while its enable bit is set. An input-full interrupt goes to the management side when its enable bit is set. No interrupt is raised when the output byte is drained, so management software must poll the output-full flag. Each management write to the output byte also produces a one-cycle event, which can be used to interrupt the host.

Top module: `kcs_mbox_chan`

## Requirements
- R1: After reset the status byte reads 0x00, the control register reads 0x00, `ibf_irq` and `odr_written` are low, and no host access is claimed.
- R2: While the channel-enable bit (control bit 0) is clear, `host_claim` stays low and host writes leave the status byte and the input byte unchanged.
- R3: Without override, the status address equals the data address plus 4 when `cfg_wide_stride` is 1, and plus 1 when it is 0. The sum wraps modulo 2^16.
- R4: When `cfg_stat_override` is 1, only `cfg_stat_addr` acts as the status address, and the inferred address is no longer claimed.
- R5: A host write stores its byte in the input byte register and sets IBF (status bit 1). CD (status bit 3) is cleared by a write to the data address and set by a write to the status address.
- R6: A host read of the data address returns the output byte and clears OBF (status bit 0). A host read of the status address returns the status byte and changes nothing.
- R7: A management read of the input byte (select 0) returns it and clears IBF. If a host write arrives in the same cycle, IBF ends up set.
- R8: A management write to the output byte (select 1) sets OBF. `odr_written` is high for exactly the one cycle that follows the write edge.
- R9: A management write to the status byte (select 2) updates only bits 2 and 7:4. Bits 0, 1 and 3 ignore the written value.
- R10: `ibf_irq` is high exactly when IBF is set and the interrupt-enable bit (control bit 1) is set. That bit is cleared by reset.
- R11: Management selects are 0 input byte, 1 output byte (also readable), 2 status byte, and 3 control (bit 0 channel enable, bit 1 input-full interrupt enable). Reads have no latency.
- R12: If the status address equals the data address, a host access at that address is treated as a data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_data_addr | input | 16 | Host I/O data address |
| cfg_wide_stride | input | 1 | Inferred status offset: 1 selects +4, 0 selects +1 |
| cfg_stat_override | input | 1 | Use `cfg_stat_addr` as the status address |
| cfg_stat_addr | input | 16 | Explicit status address |
| host_addr | input | 16 | Host access address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| host_claim | output | 1 | Channel decodes the current host access |
| mgmt_sel | input | 2 | Management register select |
| mgmt_wr | input | 1 | Management write strobe |
| mgmt_rd | input | 1 | Management read strobe |
| mgmt_wdata | input | 8 | Management write byte |
| mgmt_rdata | output | 8 | Management read byte, combinational |
| ibf_irq | output | 1 | Input-full interrupt to the management side |
| odr_written | output | 1 | One-cycle event after an output-byte write |

## Verification
The bench sweeps host addresses in a window around several data addresses, including 0xFFFF and 0x0000, in all three status-address modes. A decoder that failed to wrap, used the wrong stride, or kept claiming the inferred address under override would claim the wrong addresses. Two same-cycle collisions are provoked: a host write racing a management input-byte read, and an explicit status address equal to the data address. A design with the wrong priority would lose IBF in the first case or set CD in the second. Status writes are made with the hardware flags both set and clear, so a write that leaks into bits 0, 1 or 3 shows up in the next status read. The width of the output-write event is sampled on the cycle after the write and the cycle after that.

// File: rtl/kcs_mbox_pkg.sv
package kcs_mbox_pkg;
  localparam int BYTE_W = 8;

  localparam int STS_OBF = 0;
  localparam int STS_IBF = 1;
  localparam int STS_CD  = 3;
  localparam logic [BYTE_W-1:0] STS_SW_MASK = 8'hF4;

  localparam int CTL_CHEN  = 0;
  localparam int CTL_IBFIE = 1;

  typedef enum logic [1:0] {
    MREG_IDR = 2'd0,
    MREG_ODR = 2'd1,
    MREG_STS = 2'd2,
    MREG_CTL = 2'd3
  } mreg_e;
endpackage

// File: rtl/kcs_addr_decode.sv
module kcs_addr_decode #(
  parameter int AW       = 16,
  parameter int STRIDE_W = 4,
  parameter int STRIDE_N = 1
) (
  input  logic          enable,
  input  logic [AW-1:0] data_addr,
  input  logic          wide_stride,
  input  logic          stat_override,
  input  logic [AW-1:0] stat_addr_cfg,
  input  logic [AW-1:0] host_addr,
  input  logic          host_active,
  output logic          hit_data,
  output logic          hit_stat
);
  localparam logic [AW-1:0] OFS_W = AW'(STRIDE_W);
  localparam logic [AW-1:0] OFS_N = AW'(STRIDE_N);

  logic [AW-1:0] inferred_addr;
  logic [AW-1:0] stat_addr;
  logic          data_match;
  logic          stat_match;

  always_comb begin
    inferred_addr = data_addr + (wide_stride ? OFS_W : OFS_N);
    stat_addr     = stat_override ? stat_addr_cfg : inferred_addr;
    data_match    = (host_addr == data_addr);
    stat_match    = (host_addr == stat_addr);
    hit_data      = enable & host_active & data_match;
    hit_stat      = enable & host_active & stat_match & ~data_match;
  end
endmodule

// File: rtl/kcs_mbox_regs.sv
module kcs_mbox_regs import kcs_mbox_pkg::*; #(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_data,
  input  logic          host_wr_stat,
  input  logic          host_rd_data,
  input  logic [DW-1:0] host_wdata,
  input  logic          mgmt_idr_rd,
  input  logic          mgmt_odr_wr,
  input  logic          mgmt_sts_wr,
  input  logic          mgmt_ctl_wr,
  input  logic [DW-1:0] mgmt_wdata,
  output logic [DW-1:0] idr,
  output logic [DW-1:0] odr,
  output logic [DW-1:0] status,
  output logic          chan_en,
  output logic          ibf_ie,
  output logic          odr_evt
);
  logic          obf_q, obf_d;
  logic          ibf_q, ibf_d;
  logic          cd_q, cd_d;
  logic [DW-1:0] sw_q, sw_d;
  logic [DW-1:0] idr_q, idr_d;
  logic [DW-1:0] odr_q, odr_d;
  logic          chen_q, chen_d;
  logic          ie_q, ie_d;
  logic          evt_q, evt_d;
  logic          host_wr_any;

  always_comb begin
    host_wr_any = host_wr_data | host_wr_stat;

    obf_d = obf_q;
    if (host_rd_data) obf_d = 1'b0;
    if (mgmt_odr_wr)  obf_d = 1'b1;

    ibf_d = ibf_q;
    if (mgmt_idr_rd) ibf_d = 1'b0;
    if (host_wr_any) ibf_d = 1'b1;

    cd_d = cd_q;
    if (host_wr_data) cd_d = 1'b0;
    if (host_wr_stat) cd_d = 1'b1;

    idr_d  = host_wr_any ? host_wdata : idr_q;
    odr_d  = mgmt_odr_wr ? mgmt_wdata : odr_q;
    sw_d   = mgmt_sts_wr ? (mgmt_wdata & STS_SW_MASK) : sw_q;
    chen_d = mgmt_ctl_wr ? mgmt_wdata[CTL_CHEN]  : chen_q;
    ie_d   = mgmt_ctl_wr ? mgmt_wdata[CTL_IBFIE] : ie_q;
    evt_d  = mgmt_odr_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf_q  <= 1'b0;
      ibf_q  <= 1'b0;
      cd_q   <= 1'b0;
      sw_q   <= '0;
      idr_q  <= '0;
      odr_q  <= '0;
      chen_q <= 1'b0;
      ie_q   <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      obf_q  <= obf_d;
      ibf_q  <= ibf_d;
      cd_q   <= cd_d;
      sw_q   <= sw_d;
      idr_q  <= idr_d;
      odr_q  <= odr_d;
      chen_q <= chen_d;
      ie_q   <= ie_d;
      evt_q  <= evt_d;
    end
  end

  always_comb begin
    status          = sw_q;
    status[STS_OBF] = obf_q;
    status[STS_IBF] = ibf_q;
    status[STS_CD]  = cd_q;
  end

  assign idr     = idr_q;
  assign odr     = odr_q;
  assign chan_en = chen_q;
  assign ibf_ie  = ie_q;
  assign odr_evt = evt_q;
endmodule

// File: rtl/kcs_mbox_chan.sv
module kcs_mbox_chan import kcs_mbox_pkg::*; #(
  parameter int AW       = 16,
  parameter int DW       = BYTE_W,
  parameter int STRIDE_W = 4,
  parameter int STRIDE_N = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_data_addr,
  input  logic          cfg_wide_stride,
  input  logic          cfg_stat_override,
  input  logic [AW-1:0] cfg_stat_addr,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_claim,
  input  logic [1:0]    mgmt_sel,
  input  logic          mgmt_wr,
  input  logic          mgmt_rd,
  input  logic [DW-1:0] mgmt_wdata,
  output logic [DW-1:0] mgmt_rdata,
  output logic          ibf_irq,
  output logic          odr_written
);
  logic          hit_data, hit_stat;
  logic [DW-1:0] idr, odr, sts;
  logic          chan_en, ibf_ie;
  mreg_e         sel;

  assign sel = mreg_e'(mgmt_sel);

  kcs_addr_decode #(
    .AW(AW), .STRIDE_W(STRIDE_W), .STRIDE_N(STRIDE_N)
  ) u_dec (
    .enable        (chan_en),
    .data_addr     (cfg_data_addr),
    .wide_stride   (cfg_wide_stride),
    .stat_override (cfg_stat_override),
    .stat_addr_cfg (cfg_stat_addr),
    .host_addr     (host_addr),
    .host_active   (host_wr | host_rd),
    .hit_data      (hit_data),
    .hit_stat      (hit_stat)
  );

  kcs_mbox_regs #(.DW(DW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_data (hit_data & host_wr),
    .host_wr_stat (hit_stat & host_wr),
    .host_rd_data (hit_data & host_rd & ~host_wr),
    .host_wdata   (host_wdata),
    .mgmt_idr_rd  (mgmt_rd & (sel == MREG_IDR)),
    .mgmt_odr_wr  (mgmt_wr & (sel == MREG_ODR)),
    .mgmt_sts_wr  (mgmt_wr & (sel == MREG_STS)),
    .mgmt_ctl_wr  (mgmt_wr & (sel == MREG_CTL)),
    .mgmt_wdata   (mgmt_wdata),
    .idr          (idr),
    .odr          (odr),
    .status       (sts),
    .chan_en      (chan_en),
    .ibf_ie       (ibf_ie),
    .odr_evt      (odr_written)
  );

  always_comb begin
    host_claim = hit_data | hit_stat;
    host_rdata = '0;
    if (hit_data)      host_rdata = odr;
    else if (hit_stat) host_rdata = sts;
  end

  always_comb begin
    unique case (sel)
      MREG_IDR: mgmt_rdata = idr;
      MREG_ODR: mgmt_rdata = odr;
      MREG_STS: mgmt_rdata = sts;
      default: begin
        mgmt_rdata            = '0;
        mgmt_rdata[CTL_CHEN]  = chan_en;
        mgmt_rdata[CTL_IBFIE] = ibf_ie;
      end
    endcase
  end

  assign ibf_irq = sts[STS_IBF] & ibf_ie;
endmodule

// File: rtl/kcs_mbox_chan_chk.sv
module kcs_mbox_chan_chk import kcs_mbox_pkg::*; #(
  parameter int DW = BYTE_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] host_wdata,
  input logic          host_claim,
  input logic          hit_data,
  input logic          hit_stat,
  input logic [1:0]    mgmt_sel,
  input logic          mgmt_wr,
  input logic [DW-1:0] sts,
  input logic [DW-1:0] idr,
  input logic          chan_en,
  input logic          ibf_irq,
  input logic          odr_written
);
  // R2
  off_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !host_claim);
  // R5
  data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && host_wr) |=> (sts[STS_IBF] && !sts[STS_CD] && idr == $past(host_wdata)));
  // R5
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stat && host_wr) |=> (sts[STS_IBF] && sts[STS_CD]));
  // R6
  host_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && host_rd && !host_wr && !(mgmt_wr && mgmt_sel == 2'd1)) |=> !sts[STS_OBF]);
  // R8
  odr_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_wr && mgmt_sel == 2'd1) |=> (odr_written && sts[STS_OBF]));
  // R8
  odr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odr_written |-> $past(mgmt_wr && mgmt_sel == 2'd1));
  // R10
  irq_needs_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_irq |-> sts[STS_IBF]);
endmodule

bind kcs_mbox_chan kcs_mbox_chan_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_wdata  (host_wdata),
  .host_claim  (host_claim),
  .hit_data    (hit_data),
  .hit_stat    (hit_stat),
  .mgmt_sel    (mgmt_sel),
  .mgmt_wr     (mgmt_wr),
  .sts         (sts),
  .idr         (idr),
  .chan_en     (chan_en),
  .ibf_irq     (ibf_irq),
  .odr_written (odr_written)
);

// File: tb/kcs_mbox_chan_tb.sv
`timescale 1ns/1ps
module kcs_mbox_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_data_addr = 16'h0CA2;
  logic        cfg_wide_stride = 1'b0;
  logic        cfg_stat_override = 1'b0;
  logic [15:0] cfg_stat_addr = 16'h0000;
  logic [15:0] host_addr = 16'h0000;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        host_claim;
  logic [1:0]  mgmt_sel = 2'd0;
  logic        mgmt_wr = 1'b0, mgmt_rd = 1'b0;
  logic [7:0]  mgmt_wdata = 8'h00;
  logic [7:0]  mgmt_rdata;
  logic        ibf_irq, odr_written;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  kcs_mbox_chan dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_data_addr(cfg_data_addr), .cfg_wide_stride(cfg_wide_stride),
    .cfg_stat_override(cfg_stat_override), .cfg_stat_addr(cfg_stat_addr),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_claim(host_claim),
    .mgmt_sel(mgmt_sel), .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd),
    .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
    .ibf_irq(ibf_irq), .odr_written(odr_written)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mwr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); mgmt_sel = s; mgmt_wdata = d; mgmt_wr = 1'b1;
    @(negedge clk); mgmt_wr = 1'b0;
  endtask

  task automatic mrd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); mgmt_sel = s; mgmt_rd = 1'b1;
    #1 d = mgmt_rdata;
    @(negedge clk); mgmt_rd = 1'b0;
  endtask

  task automatic hwr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [15:0] a, output logic [7:0] d, output logic c);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata; c = host_claim;
    @(negedge clk); host_rd = 1'b0;
  endtask

  function automatic logic [15:0] stat_of(input logic [15:0] d, input int mode, input logic [15:0] sa);
    if (mode == 2) return sa;
    return d + ((mode == 1) ? 16'd4 : 16'd1);
  endfunction

  initial begin
    logic [7:0] rd;
    logic       c;
    logic [15:0] dlist [5] = '{16'h0CA0, 16'h0CA2, 16'hFFFF, 16'h0000, 16'h0060};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    mrd(2'd2, rd); chk("R1 status", rd, 8'h00);
    mrd(2'd3, rd); chk("R1 control", rd, 8'h00);
    chk("R1 ibf_irq", ibf_irq, 1'b0);
    chk("R1 odr_written", odr_written, 1'b0);
    hrd(16'h0CA2, rd, c); chk("R1 R2 no claim", c, 1'b0);

    // R2 disabled channel ignores writes
    hwr(16'h0CA2, 8'h11);
    hwr(16'h0CA3, 8'h22);
    mrd(2'd2, rd); chk("R2 status untouched", rd, 8'h00);
    mrd(2'd0, rd); chk("R2 idr untouched", rd, 8'h00);

    // R11 enable channel, read control back
    mwr(2'd3, 8'h01);
    mrd(2'd3, rd); chk("R11 control", rd, 8'h01);

    // R3 R4 R12 address sweep
    foreach (dlist[i]) begin
      for (int m = 0; m < 3; m++) begin
        logic [15:0] d;
        logic [15:0] sa;
        logic [15:0] st;
        d  = dlist[i];
        sa = (d == 16'h0060) ? d : d + 16'h0010;
        st = stat_of(d, m, sa);
        @(negedge clk);
        cfg_data_addr = d; cfg_wide_stride = (m == 1);
        cfg_stat_override = (m == 2); cfg_stat_addr = sa;
        for (int off = -2; off <= 6; off++) begin
          logic [15:0] a;
          a = 16'(int'(d) + off);
          hrd(a, rd, c);
          chk((m == 2) ? "R4 claim" : "R3 claim", c, (a == d) || (a == st));
        end
        hrd(sa, rd, c);
        chk("R4 explicit addr", c, (m == 2) || (sa == d) || (sa == st));
      end
    end

    // R12 coinciding addresses: data wins, CD stays 0
    @(negedge clk);
    cfg_data_addr = 16'h0060; cfg_stat_override = 1'b1; cfg_stat_addr = 16'h0060;
    hwr(16'h0060, 8'h9E);
    mrd(2'd2, rd); chk("R12 data wins", rd, 8'h02);
    mrd(2'd0, rd); chk("R7 idr", rd, 8'h9E);

    // standard setup: data 0xCA0, wide stride
    @(negedge clk);
    cfg_data_addr = 16'h0CA0; cfg_wide_stride = 1'b1; cfg_stat_override = 1'b0;

    // R5 R10 data write with irq disabled
    hwr(16'h0CA0, 8'h5A);
    chk("R10 irq masked", ibf_irq, 1'b0);
    mrd(2'd2, rd); chk("R5 status after data wr", rd, 8'h02);
    mrd(2'd0, rd); chk("R7 idr data", rd, 8'h5A);
    mrd(2'd2, rd); chk("R7 ibf cleared", rd, 8'h00);

    // R5 R10 command write with irq enabled
    mwr(2'd3, 8'h03);
    hwr(16'h0CA4, 8'hC3);
    chk("R10 irq raised", ibf_irq, 1'b1);
    mrd(2'd2, rd); chk("R5 status after cmd wr", rd, 8'h0A);
    mrd(2'd0, rd); chk("R5 idr cmd", rd, 8'hC3);
    chk("R10 irq dropped", ibf_irq, 1'b0);

    // R7 same-cycle host write and idr read
    @(negedge clk);
    host_addr = 16'h0CA0; host_wdata = 8'h44; host_wr = 1'b1;
    mgmt_sel = 2'd0; mgmt_rd = 1'b1;
    @(negedge clk); host_wr = 1'b0; mgmt_rd = 1'b0;
    mrd(2'd2, rd); chk("R7 collision ibf kept", rd, 8'h02);
    mrd(2'd0, rd); chk("R7 collision idr", rd, 8'h44);

    // R8 odr write event
    mwr(2'd1, 8'h77);
    chk("R8 event high", odr_written, 1'b1);
    @(negedge clk);
    chk("R8 event one cycle", odr_written, 1'b0);
    mrd(2'd1, rd); chk("R11 odr readback", rd, 8'h77);

    // R6 host reads
    hrd(16'h0CA4, rd, c); chk("R6 status read", rd, 8'h01);
    mrd(2'd2, rd); chk("R6 status read no effect", rd, 8'h01);
    hrd(16'h0CA0, rd, c); chk("R6 data read", rd, 8'h77);
    mrd(2'd2, rd); chk("R6 obf cleared", rd, 8'h00);

    // R9 software bits only
    mwr(2'd2, 8'hFF);
    mrd(2'd2, rd); chk("R9 sw bits set", rd, 8'hF4);
    mwr(2'd1, 8'h10);
    hwr(16'h0CA4, 8'h01);
    mwr(2'd2, 8'h00);
    mrd(2'd2, rd); chk("R9 hw bits kept", rd, 8'h0B);

    // R2 disable again: no claim
    mwr(2'd3, 8'h00);
    hrd(16'h0CA0, rd, c); chk("R2 disabled claim", c, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule